// File: doc/BRIEF.md
# Operand Resolver with Cycle Costing

This block works out the operand of one instruction for an 8-bit processor core with a 16-bit address space. The core gives it an addressing-mode code, the 16-bit operand field, the two index registers, the accumulator and an operation-class code, then pulses `start`. The block forms the effective address, wrapping it inside page zero where the mode asks for that. For the two pointer modes it first fetches a 16-bit pointer, low byte first. It then reads the operand byte through a synchronous byte-wide read port.

When the work is finished, the block pulses `done` for one cycle. In that cycle it presents the operand value, the instruction length in bytes, and the total cycle cost of the instruction. The cost comes from a per-class table. For the arithmetic/logic/load class, one more cycle is added when indexing moves the address into another 256-byte page. The block does not execute the operation, fetch opcodes or touch the program counter.

Top module: `opnd_resolve`

## Requirements
- R1: Mode codes are immediate 0, accumulator 1, zero page 2, zero page+X 3, zero page+Y 4, absolute 5, absolute+X 6, absolute+Y 7, pre-indexed pointer 8, post-indexed pointer 9, and implied 10 to 15. The zero-page modes read at the low byte of the operand, or at the low byte plus X or Y, modulo 256. The upper address byte is zero. Absolute modes read at the operand, or at the operand plus X or Y, modulo 65536.
- R2: In mode 8, the pointer's low byte is read at (operand low byte + X) mod 256 and its high byte at the next zero-page location, with 0xFF wrapping to 0x00. The operand is then read at that pointer.
- R3: In mode 9, the pointer is read at the operand low byte and the next zero-page location, with the same wrap. Y is added to it as a 16-bit sum, and the operand is read at the result.
- R4: Immediate mode returns the operand low byte, accumulator mode returns the accumulator, and implied modes return 0. None of these three cases reads memory.
- R5: The length is 3 for modes 5, 6 and 7, 1 for mode 1, and 2 for every other mode.
- R6: Classes 0 (load/logic/add/compare) and 1 (bit test, index stores) cost 2 in mode 0, 3 in mode 2, 4 in modes 3, 4, 5, 6 and 7, 6 in mode 8, and 5 in mode 9.
- R7: Class 2 (read-modify-write) costs 2 in mode 1, 5 in mode 2, 6 in modes 3 and 5, and 7 in mode 6.
- R8: Class 3 (accumulator store) costs 3 in mode 2, 4 in modes 3 and 5, 5 in modes 6 and 7, and 6 in modes 8 and 9.
- R9: Fixed costs are: class 4 (break) 7; class 5 (returns and subroutine call) 6; class 6 (jump) 5; class 7 (pull) 4; class 8 (push) 3. Classes 9 to 15 cost 2, and so does any mode not listed for classes 0 to 3.
- R10: For class 0 only, in modes 6, 7 and 9, one cycle is added and `crossed` is set when the upper byte of the base address differs from the upper byte of the indexed address. Otherwise `crossed` is 0.
- R11: `done` is high for exactly one cycle. Count the edge that samples `start` as edge 0. `done` is then high after edge 1 when no memory is read, after edge 2 for one direct read, and after edge 5 for the pointer modes. Read data is taken one cycle after its address is presented with `mem_rd` high.
- R12: `start` is ignored while a request is in progress. The result then matches the inputs sampled at the accepted start, and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| mode | input | 4 | Addressing-mode code |
| opclass | input | 4 | Operation-class code |
| operand | input | 16 | Operand field of the instruction |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc | input | 8 | Accumulator |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| value | output | 8 | Resolved operand byte |
| length | output | 2 | Instruction length in bytes |
| cycles | output | 4 | Total cycle cost |
| crossed | output | 1 | Page-cross penalty was applied |

## Verification
The bench builds the block with its default 8-bit data and 16-bit address widths, with pointer fetches wrapping in page zero. At these sizes, an 8-bit index sum can actually overflow a page. A pointer placed at location 0xFF therefore shows the wrap: its high byte comes back from 0x00, and the bench memory returns a different value there than at 0x0100. Index values near 0xFF and bases near a page end drive both the crossing and the non-crossing outcome for every class that could take the penalty.

// File: rtl/opr_pkg.sv
package opr_pkg;

  localparam int MODE_W = 4;
  localparam int CLS_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 4'd0,
    AM_ACC = 4'd1,
    AM_ZPG = 4'd2,
    AM_ZPX = 4'd3,
    AM_ZPY = 4'd4,
    AM_ABS = 4'd5,
    AM_ABX = 4'd6,
    AM_ABY = 4'd7,
    AM_IDX = 4'd8,
    AM_IDY = 4'd9,
    AM_IMP = 4'd10
  } amode_e;

  typedef enum logic [CLS_W-1:0] {
    OC_LOAD = 4'd0,
    OC_READ = 4'd1,
    OC_RMW  = 4'd2,
    OC_STA  = 4'd3,
    OC_BRK  = 4'd4,
    OC_RET  = 4'd5,
    OC_JMP  = 4'd6,
    OC_PULL = 4'd7,
    OC_PUSH = 4'd8,
    OC_MISC = 4'd9
  } oclass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLO,
    ST_PHI,
    ST_PHW,
    ST_OADR,
    ST_OWAIT,
    ST_FIN
  } rstate_e;

  function automatic logic mode_is_ptr(input amode_e m);
    return (m == AM_IDX) || (m == AM_IDY);
  endfunction

  function automatic logic mode_is_direct(input amode_e m);
    return (m == AM_ZPG) || (m == AM_ZPX) || (m == AM_ZPY) ||
           (m == AM_ABS) || (m == AM_ABX) || (m == AM_ABY);
  endfunction

  function automatic logic mode_is_zp(input amode_e m);
    return (m == AM_ZPG) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction

endpackage

// File: rtl/opr_ea_unit.sv
module opr_ea_unit
  import opr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2 * DATA_W,
  parameter bit PTR_WRAP = 1'b1
) (
  input  amode_e            mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] ptr_lo,
  input  logic [DATA_W-1:0] ptr_hi,
  output logic [ADDR_W-1:0] ptr_lo_addr,
  output logic [ADDR_W-1:0] ptr_hi_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              page_diff
);

  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] op_lo;
  logic [DATA_W-1:0] zp_base;
  logic [DATA_W-1:0] zp_sum_x;
  logic [DATA_W-1:0] zp_sum_y;
  logic [ADDR_W-1:0] pointer;
  logic [ADDR_W-1:0] x_ext;
  logic [ADDR_W-1:0] y_ext;
  logic [ADDR_W-1:0] base_addr;

  assign op_lo    = operand[DATA_W-1:0];
  assign zp_sum_x = op_lo + idx_x;
  assign zp_sum_y = op_lo + idx_y;
  assign zp_base  = (mode == AM_IDX) ? zp_sum_x : op_lo;
  assign pointer  = {ptr_hi, ptr_lo};
  assign x_ext    = {{PAGE_W{1'b0}}, idx_x};
  assign y_ext    = {{PAGE_W{1'b0}}, idx_y};

  assign ptr_lo_addr = {{PAGE_W{1'b0}}, zp_base};

  generate
    if (PTR_WRAP) begin : g_ptr_wrap
      logic [DATA_W-1:0] zp_next;
      assign zp_next     = zp_base + DATA_W'(1);
      assign ptr_hi_addr = {{PAGE_W{1'b0}}, zp_next};
    end else begin : g_ptr_linear
      assign ptr_hi_addr = ptr_lo_addr + ADDR_W'(1);
    end
  endgenerate

  always_comb begin
    case (mode)
      AM_ZPG:  eff_addr = {{PAGE_W{1'b0}}, op_lo};
      AM_ZPX:  eff_addr = {{PAGE_W{1'b0}}, zp_sum_x};
      AM_ZPY:  eff_addr = {{PAGE_W{1'b0}}, zp_sum_y};
      AM_ABX:  eff_addr = operand + x_ext;
      AM_ABY:  eff_addr = operand + y_ext;
      AM_IDX:  eff_addr = pointer;
      AM_IDY:  eff_addr = pointer + y_ext;
      default: eff_addr = operand;
    endcase
  end

  always_comb begin
    case (mode)
      AM_ABX, AM_ABY: base_addr = operand;
      AM_IDY:         base_addr = pointer;
      default:        base_addr = eff_addr;
    endcase
  end

  assign page_diff = (base_addr[ADDR_W-1:DATA_W] != eff_addr[ADDR_W-1:DATA_W]);

endmodule

// File: rtl/opr_cost_table.sv
module opr_cost_table
  import opr_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  amode_e           mode,
  input  oclass_e          opclass,
  input  logic             page_diff,
  output logic [CYC_W-1:0] cycles,
  output logic [1:0]       length,
  output logic             penalty
);

  logic [CYC_W-1:0] base_cyc;

  always_comb begin
    case (mode)
      AM_ABS, AM_ABX, AM_ABY: length = 2'd3;
      AM_ACC:                 length = 2'd1;
      default:                length = 2'd2;
    endcase
  end

  always_comb begin
    base_cyc = CYC_W'(2);
    case (opclass)
      OC_LOAD, OC_READ: begin
        case (mode)
          AM_ZPG:                                 base_cyc = CYC_W'(3);
          AM_ZPX, AM_ZPY, AM_ABS, AM_ABX, AM_ABY: base_cyc = CYC_W'(4);
          AM_IDX:                                 base_cyc = CYC_W'(6);
          AM_IDY:                                 base_cyc = CYC_W'(5);
          default:                                base_cyc = CYC_W'(2);
        endcase
      end
      OC_RMW: begin
        case (mode)
          AM_ZPG:         base_cyc = CYC_W'(5);
          AM_ZPX, AM_ABS: base_cyc = CYC_W'(6);
          AM_ABX:         base_cyc = CYC_W'(7);
          default:        base_cyc = CYC_W'(2);
        endcase
      end
      OC_STA: begin
        case (mode)
          AM_ZPG:         base_cyc = CYC_W'(3);
          AM_ZPX, AM_ABS: base_cyc = CYC_W'(4);
          AM_ABX, AM_ABY: base_cyc = CYC_W'(5);
          AM_IDX, AM_IDY: base_cyc = CYC_W'(6);
          default:        base_cyc = CYC_W'(2);
        endcase
      end
      OC_BRK:  base_cyc = CYC_W'(7);
      OC_RET:  base_cyc = CYC_W'(6);
      OC_JMP:  base_cyc = CYC_W'(5);
      OC_PULL: base_cyc = CYC_W'(4);
      OC_PUSH: base_cyc = CYC_W'(3);
      default: base_cyc = CYC_W'(2);
    endcase
  end

  assign penalty = (opclass == OC_LOAD) && page_diff &&
                   ((mode == AM_ABX) || (mode == AM_ABY) || (mode == AM_IDY));

  assign cycles = base_cyc + CYC_W'(penalty);

endmodule

// File: rtl/opnd_resolve.sv
module opnd_resolve
  import opr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2 * DATA_W,
  parameter int CYC_W    = 4,
  parameter bit PTR_WRAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [CLS_W-1:0]  opclass,
  input  logic [ADDR_W-1:0] operand,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] value,
  output logic [1:0]        length,
  output logic [CYC_W-1:0]  cycles,
  output logic              crossed
);

  rstate_e           state_q;
  amode_e            mode_q;
  oclass_e           cls_q;
  logic [ADDR_W-1:0] op_q;
  logic [DATA_W-1:0] x_q;
  logic [DATA_W-1:0] y_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] ptr_lo_q;
  logic [DATA_W-1:0] ptr_hi_q;

  logic [ADDR_W-1:0] ptr_lo_addr;
  logic [ADDR_W-1:0] ptr_hi_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic              page_diff;
  logic [CYC_W-1:0]  cost_cyc;
  logic [1:0]        cost_len;
  logic              cost_pen;
  logic [DATA_W-1:0] inline_val;

  logic              busy;
  logic              ptr_phase;
  logic              zp_phase;

  opr_ea_unit #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .PTR_WRAP(PTR_WRAP)
  ) i_ea (
    .mode       (mode_q),
    .operand    (op_q),
    .idx_x      (x_q),
    .idx_y      (y_q),
    .ptr_lo     (ptr_lo_q),
    .ptr_hi     (ptr_hi_q),
    .ptr_lo_addr(ptr_lo_addr),
    .ptr_hi_addr(ptr_hi_addr),
    .eff_addr   (eff_addr),
    .page_diff  (page_diff)
  );

  opr_cost_table #(
    .CYC_W(CYC_W)
  ) i_cost (
    .mode     (mode_q),
    .opclass  (cls_q),
    .page_diff(page_diff),
    .cycles   (cost_cyc),
    .length   (cost_len),
    .penalty  (cost_pen)
  );

  always_comb begin
    case (mode_q)
      AM_IMM:  inline_val = op_q[DATA_W-1:0];
      AM_ACC:  inline_val = a_q;
      default: inline_val = '0;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_PLO:  mem_addr = ptr_lo_addr;
      ST_PHI:  mem_addr = ptr_hi_addr;
      default: mem_addr = eff_addr;
    endcase
  end

  assign mem_rd    = (state_q == ST_PLO) || (state_q == ST_PHI) || (state_q == ST_OADR);
  assign busy      = (state_q != ST_IDLE);
  assign ptr_phase = (state_q == ST_PLO) || (state_q == ST_PHI);
  assign zp_phase  = (state_q == ST_OADR) && mode_is_zp(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= AM_IMP;
      cls_q    <= OC_MISC;
      op_q     <= '0;
      x_q      <= '0;
      y_q      <= '0;
      a_q      <= '0;
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
      done     <= 1'b0;
      value    <= '0;
      length   <= '0;
      cycles   <= '0;
      crossed  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q <= amode_e'(mode);
            cls_q  <= oclass_e'(opclass);
            op_q   <= operand;
            x_q    <= idx_x;
            y_q    <= idx_y;
            a_q    <= acc;
            if (mode_is_ptr(amode_e'(mode)))
              state_q <= ST_PLO;
            else if (mode_is_direct(amode_e'(mode)))
              state_q <= ST_OADR;
            else
              state_q <= ST_FIN;
          end
        end
        ST_PLO: state_q <= ST_PHI;
        ST_PHI: begin
          ptr_lo_q <= mem_rdata;
          state_q  <= ST_PHW;
        end
        ST_PHW: begin
          ptr_hi_q <= mem_rdata;
          state_q  <= ST_OADR;
        end
        ST_OADR: state_q <= ST_OWAIT;
        ST_OWAIT: begin
          value   <= mem_rdata;
          length  <= cost_len;
          cycles  <= cost_cyc;
          crossed <= cost_pen;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_FIN: begin
          value   <= inline_val;
          length  <= cost_len;
          cycles  <= cost_cyc;
          crossed <= cost_pen;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opnd_resolve_chk.sv
module opnd_resolve_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter int CYC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        length,
  input logic [CYC_W-1:0]  cycles,
  input logic              crossed,
  input logic              busy,
  input logic              ptr_phase,
  input logic              zp_phase,
  input logic [3:0]        mode_q
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done held"); // R11

  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd) else $error("read during done"); // R11

  AST_PTR_IN_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ptr_phase |-> (mem_addr[ADDR_W-1:DATA_W] == '0)) else $error("pointer fetch outside page zero"); // R2

  AST_ZP_MODE_ADDR: assert property (@(posedge clk) disable iff (rst)
    zp_phase |-> (mem_addr[ADDR_W-1:DATA_W] == '0)) else $error("zero-page read outside page zero"); // R1

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (length != 2'd0)) else $error("bad length"); // R5

  AST_PENALTY_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (done && crossed) |-> (cycles >= CYC_W'(5))) else $error("penalty on short cost"); // R10

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q)) else $error("request taken while busy"); // R12

endmodule

bind opnd_resolve opnd_resolve_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .CYC_W (CYC_W)
) i_opnd_resolve_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .length   (length),
  .cycles   (cycles),
  .crossed  (crossed),
  .busy     (busy),
  .ptr_phase(ptr_phase),
  .zp_phase (zp_phase),
  .mode_q   (mode_q)
);

// File: tb/test_opnd_resolve.sv
`timescale 1ns/1ps
module test_opnd_resolve;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [3:0]  opclass = '0;
  logic [15:0] operand = '0;
  logic [7:0]  idx_x = '0;
  logic [7:0]  idx_y = '0;
  logic [7:0]  acc = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [7:0]  value;
  logic [1:0]  length;
  logic [3:0]  cycles;
  logic        crossed;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int start_cyc = 0;
  int sent = 0;
  int seen = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] val;
    logic [1:0] len;
    logic [3:0] cost;
    logic       crs;
    int         lat;
    string      req;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  opnd_resolve i_opnd_resolve (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opclass(opclass),
    .operand(operand), .idx_x(idx_x), .idx_y(idx_y), .acc(acc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .value(value), .length(length), .cycles(cycles), .crossed(crossed)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] m, input logic [3:0] c,
                                 input logic [15:0] op, input logic [7:0] x,
                                 input logic [7:0] y, input logic [7:0] a,
                                 input string req);
    exp_t e;
    logic [15:0] ea, base;
    logic [7:0] p;
    bit rd, cross_ok;
    int cost;
    rd = 1; base = 16'h0; ea = 16'h0; cross_ok = 0;
    case (m)
      4'd2: ea = {8'h00, op[7:0]};
      4'd3: ea = {8'h00, 8'(op[7:0] + x)};
      4'd4: ea = {8'h00, 8'(op[7:0] + y)};
      4'd5: ea = op;
      4'd6: begin base = op; ea = op + {8'h00, x}; cross_ok = 1; end
      4'd7: begin base = op; ea = op + {8'h00, y}; cross_ok = 1; end
      4'd8: begin
        p = op[7:0] + x;
        ea = {memf({8'h00, 8'(p + 8'd1)}), memf({8'h00, p})};
      end
      4'd9: begin
        p = op[7:0];
        base = {memf({8'h00, 8'(p + 8'd1)}), memf({8'h00, p})};
        ea = base + {8'h00, y}; cross_ok = 1;
      end
      default: rd = 0;
    endcase
    if (rd) e.val = memf(ea);
    else if (m == 4'd0) e.val = op[7:0];
    else if (m == 4'd1) e.val = a;
    else e.val = 8'h00;
    e.len = (m >= 4'd5 && m <= 4'd7) ? 2'd3 : (m == 4'd1) ? 2'd1 : 2'd2;
    cost = 2;
    case (c)
      4'd0, 4'd1: case (m)
        4'd2: cost = 3;
        4'd3, 4'd4, 4'd5, 4'd6, 4'd7: cost = 4;
        4'd8: cost = 6;
        4'd9: cost = 5;
        default: cost = 2;
      endcase
      4'd2: case (m)
        4'd2: cost = 5;
        4'd3, 4'd5: cost = 6;
        4'd6: cost = 7;
        default: cost = 2;
      endcase
      4'd3: case (m)
        4'd2: cost = 3;
        4'd3, 4'd5: cost = 4;
        4'd6, 4'd7: cost = 5;
        4'd8, 4'd9: cost = 6;
        default: cost = 2;
      endcase
      4'd4: cost = 7;
      4'd5: cost = 6;
      4'd6: cost = 5;
      4'd7: cost = 4;
      4'd8: cost = 3;
      default: cost = 2;
    endcase
    e.crs = (c == 4'd0) && cross_ok && (base[15:8] != ea[15:8]);
    e.cost = 4'(cost + int'(e.crs));
    e.lat = (m == 4'd8 || m == 4'd9) ? 6 : rd ? 3 : 2;
    e.req = req;
    return e;
  endfunction

  // driver: pushes the expected item, then drives one request
  task automatic issue(input logic [3:0] m, input logic [3:0] c, input logic [15:0] op,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                       input string req, input bit poke = 0);
    sb.push_back(model(m, c, op, x, y, a, req));
    @(negedge clk);
    mode = m; opclass = c; operand = op; idx_x = x; idx_y = y; acc = a;
    start = 1'b1; start_cyc = cyc; sent++;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: second request while busy, with different inputs
      mode = 4'd0; opclass = 4'd4; operand = 16'hFFFF; idx_x = 8'h77; idx_y = 8'h66; acc = 8'h55;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (seen == sent);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops and compares on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      seen++;
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "value", int'(value), int'(e.val));
        chk(e.req, "length R5", int'(length), int'(e.len));
        chk(e.req, "cycles", int'(cycles), int'(e.cost));
        chk(e.req, "crossed R10", int'(crossed), int'(e.crs));
        chk(e.req, "latency R11", cyc - start_cyc, e.lat);
      end
    end
  end

  int done_width = 0;
  always @(negedge clk) begin
    if (!rst && done) begin
      done_width++;
      if (done_width > 1) begin
        checks++; fails++;
        $display("FAIL R11 done width: actual %0d expected 1", done_width);
      end
    end else done_width = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset done", int'(done), 0);
    chk("R11", "reset cycles", int'(cycles), 0);
    chk("R5", "reset length", int'(length), 0);
    chk("R11", "reset mem_rd", int'(mem_rd), 0);

    issue(4'd0, 4'd0, 16'h1234, 8'h00, 8'h00, 8'h99, "R4 R6 immediate");
    issue(4'd1, 4'd2, 16'h0000, 8'h00, 8'h00, 8'hA5, "R4 R7 accumulator");
    issue(4'd10, 4'd9, 16'hBEEF, 8'h01, 8'h02, 8'h03, "R4 R9 implied");
    issue(4'd2, 4'd0, 16'h1280, 8'h00, 8'h00, 8'h00, "R1 R6 zero page");
    issue(4'd3, 4'd1, 16'h00F0, 8'h20, 8'h00, 8'h00, "R1 R6 zp+X wrap");
    issue(4'd4, 4'd0, 16'h33FE, 8'h00, 8'h05, 8'h00, "R1 R6 zp+Y wrap");
    issue(4'd5, 4'd2, 16'h4321, 8'h00, 8'h00, 8'h00, "R1 R7 absolute");
    issue(4'd3, 4'd2, 16'h0010, 8'h04, 8'h00, 8'h00, "R7 zp+X rmw");
    issue(4'd2, 4'd2, 16'h0011, 8'h00, 8'h00, 8'h00, "R7 zp rmw");
    issue(4'd6, 4'd0, 16'h12F0, 8'h20, 8'h00, 8'h00, "R10 abs+X crossing");
    issue(4'd6, 4'd0, 16'h12F0, 8'h05, 8'h00, 8'h00, "R10 abs+X same page");
    issue(4'd7, 4'd0, 16'hFFF8, 8'h00, 8'h10, 8'h00, "R1 R10 abs+Y 16-bit wrap");
    issue(4'd7, 4'd1, 16'h20FF, 8'h00, 8'h01, 8'h00, "R10 no penalty class 1");
    issue(4'd6, 4'd2, 16'h20FF, 8'h01, 8'h00, 8'h00, "R7 R10 rmw abs+X");
    issue(4'd8, 4'd0, 16'h00FE, 8'h01, 8'h00, 8'h00, "R2 pointer at 0xFF");
    issue(4'd8, 4'd0, 16'h0010, 8'h30, 8'h00, 8'h00, "R2 R6 pre-indexed");
    issue(4'd9, 4'd0, 16'h0040, 8'h00, 8'hFF, 8'h00, "R3 R10 post-indexed crossing");
    issue(4'd9, 4'd0, 16'h0040, 8'h00, 8'h01, 8'h00, "R3 R6 post-indexed same page");
    issue(4'd9, 4'd1, 16'h00FF, 8'h00, 8'h02, 8'h00, "R3 pointer at 0xFF");
    issue(4'd2, 4'd3, 16'h0077, 8'h00, 8'h00, 8'h00, "R8 store zp");
    issue(4'd3, 4'd3, 16'h0077, 8'h01, 8'h00, 8'h00, "R8 store zp+X");
    issue(4'd7, 4'd3, 16'h10FF, 8'h00, 8'h01, 8'h00, "R8 store abs+Y");
    issue(4'd8, 4'd3, 16'h0020, 8'h02, 8'h00, 8'h00, "R8 store pre-indexed");
    issue(4'd9, 4'd3, 16'h0022, 8'h00, 8'hF0, 8'h00, "R8 store post-indexed");
    issue(4'd10, 4'd4, 16'h0000, 8'h00, 8'h00, 8'h00, "R9 break");
    issue(4'd10, 4'd5, 16'h0000, 8'h00, 8'h00, 8'h00, "R9 return");
    issue(4'd5, 4'd6, 16'h8000, 8'h00, 8'h00, 8'h00, "R9 jump");
    issue(4'd10, 4'd7, 16'h0000, 8'h00, 8'h00, 8'h00, "R9 pull");
    issue(4'd10, 4'd8, 16'h0000, 8'h00, 8'h00, 8'h00, "R9 push");
    issue(4'd0, 4'd2, 16'h0005, 8'h00, 8'h00, 8'h00, "R9 unlisted mode");
    issue(4'd8, 4'd0, 16'h0050, 8'h10, 8'h00, 8'h00, "R12 start while busy", 1'b1);
    issue(4'd5, 4'd0, 16'h0150, 8'h00, 8'h00, 8'h00, "R12 direct with busy poke", 1'b1);

    repeat (5) @(negedge clk);
    chk("R12", "done count", seen, sent);
    chk("R12", "queue empty", sb.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule